// File: doc/BRIEF.md
# PWM Event Interrupt and ADC Trigger Router

This block sits next to a single PWM generator and condenses that generator's internal events into one CPU interrupt request and two ADC trigger pulses. The generator supplies an end-of-cycle pulse, three compare-match pulses (A, B, C), a source pulse for ADC trigger 1, and four status levels: fault, current limit, feed-forward and sync. A 16-bit control word, loaded through a simple write strobe, holds the per-status interrupt enables, a time-base interrupt selector, the trigger 2 source enables and the trigger 1 skip count.

The interrupt request is a sticky flag. It is set by an enabled status rising edge or by the selected time-base event, and it is cleared by a one-cycle acknowledge. ADC trigger 2 pulses whenever an enabled compare event fires. ADC trigger 1 pulses once per PWM cycle, after a programmable number of its source events has been skipped.

Control word layout: bit 15 fault enable, bit 14 current-limit enable, bit 13 feed-forward enable, bit 12 sync enable, bits 9:8 time-base selector, bit 7 compare C, bit 6 compare B and bit 5 compare A trigger 2 enables, bits 4:0 trigger 1 skip count. Bits 11:10 are unused.

Top module: `pwm_evt_router`

## Requirements
- R1: A 0-to-1 change on a status input (fault, current limit, feed-forward, sync) whose enable bit (15, 14, 13, 12 respectively) is 1 sets irq_o on the next clock edge. A disabled input never sets it.
- R2: A status input that stays high raises no further requests after its first rising edge.
- R3: A status input that is already high when reset is released is not treated as a rising edge.
- R4: The time-base selector in bits 9:8 chooses the event that sets irq_o: 00 end of cycle, 01 compare A, 10 the ADC trigger 1 firing.
- R5: Selector value 11 stops all time-base interrupts, while the status-input interrupts keep working under their own enables.
- R6: adc_trig2_o pulses for one cycle, one clock after any compare event whose enable is 1 (A at bit 5, B at bit 6, C at bit 7). Disabled compare events are ignored.
- R7: With a skip count N in bits 4:0 (0 to 31), the first N trigger 1 source events of a PWM cycle are skipped, and the next one gives a one-clock adc_trig1_o pulse one clock later. Further source events in that cycle are ignored.
- R8: Each end-of-cycle pulse restarts the trigger 1 skip count. A source event in the same cycle counts toward the new PWM cycle.
- R9: irq_o stays high until irq_ack_i is applied. An acknowledge with no new event clears it on the next edge, and an event that coincides with the acknowledge keeps it set.
- R10: After reset, all outputs are 0 and the control word is zero: end-of-cycle time-base interrupts, no status enables, no trigger 2 sources, no trigger 1 skip.
- R11: A control word write is used from the clock cycle after the write strobe. Events in the write cycle still see the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 16 | Control word value |
| eoc_i | input | 1 | PWM end-of-cycle pulse |
| cmp_a_i | input | 1 | Compare A match pulse |
| cmp_b_i | input | 1 | Compare B match pulse |
| cmp_c_i | input | 1 | Compare C match pulse |
| trig1_src_i | input | 1 | ADC trigger 1 source pulse |
| fault_i | input | 1 | Fault status level |
| climit_i | input | 1 | Current-limit status level |
| ffwd_i | input | 1 | Feed-forward status level |
| sync_i | input | 1 | Sync status level |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Sticky interrupt request |
| adc_trig1_o | output | 1 | ADC trigger 1 pulse |
| adc_trig2_o | output | 1 | ADC trigger 2 pulse |

## Verification
If the previous-level flops of the status inputs hold a wrong value, irq_o rises either with no input change or on a held level, one clock after the event, and it then stays high so that it can be observed. A miscounted trigger 1 skip counter moves the adc_trig1_o pulse by whole source events, and this can be seen at the pulse position within the same PWM cycle. A missed reload shows on the first source events after the next end-of-cycle. Corrupted trigger 2 enables or a wrong selector decode give a missing or extra pulse exactly one clock after the compare or time-base event.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int CFG_W  = 16;
  localparam int OFS_W  = 5;
  localparam int NSTAT  = 4;
  localparam int NCMP   = 3;

  typedef enum logic [1:0] {
    TB_EOC   = 2'b00,
    TB_CMPA  = 2'b01,
    TB_TRIG1 = 2'b10,
    TB_OFF   = 2'b11
  } tb_sel_e;

  // st_en order: [3] fault, [2] current limit, [1] feed-forward, [0] sync
  // t2_en order: [2] compare C, [1] compare B, [0] compare A
  typedef struct packed {
    logic [NSTAT-1:0] st_en;
    logic [1:0]       unused;
    tb_sel_e          tb_sel;
    logic [NCMP-1:0]  t2_en;
    logic [OFS_W-1:0] t1_skip;
  } ctl_word_t;
endpackage

// File: rtl/pwm_rise_det.sv
module pwm_rise_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  // first cycle after reset only captures the level
  always_comb begin
    rise_o = '0;
    if (armed_q) rise_o = lvl_i & ~prev_q;
  end
endmodule

// File: rtl/pwm_trig1_skip.sv
module pwm_trig1_skip #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoc_i,
  input  logic             src_i,
  input  logic [OFS_W-1:0] skip_i,
  output logic             fire_o
);
  logic [OFS_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic             done_q, done_d, done_eff;

  always_comb begin
    cnt_eff  = eoc_i ? '0 : cnt_q;
    done_eff = eoc_i ? 1'b0 : done_q;
    fire_o   = src_i && !done_eff && (cnt_eff == skip_i);
    cnt_d    = cnt_eff;
    if (src_i && (cnt_eff < skip_i)) cnt_d = cnt_eff + 1'b1;
    done_d   = done_eff | fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/pwm_irq_flag.sv
module pwm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = set_i | (irq_q & ~ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pwm_evt_router.sv
module pwm_evt_router
  import pwm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             eoc_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic             cmp_c_i,
  input  logic             trig1_src_i,
  input  logic             fault_i,
  input  logic             climit_i,
  input  logic             ffwd_i,
  input  logic             sync_i,
  input  logic             irq_ack_i,
  output logic             irq_o,
  output logic             adc_trig1_o,
  output logic             adc_trig2_o
);
  ctl_word_t        ctl_q, ctl_d;
  logic [NSTAT-1:0] st_lvl, st_rise;
  logic [NCMP-1:0]  cmp_vec;
  logic             t1_fire, t2_fire, tb_evt, irq_set;
  logic             t1_q, t2_q;
  logic [NCMP-1:0]  t2_en_w;

  assign st_lvl  = {fault_i, climit_i, ffwd_i, sync_i};
  assign cmp_vec = {cmp_c_i, cmp_b_i, cmp_a_i};
  assign t2_en_w = ctl_q.t2_en;

  // control word, clock-enabled by the write strobe
  always_comb begin
    ctl_d = ctl_q;
    if (cfg_we_i) ctl_d = ctl_word_t'(cfg_wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  pwm_rise_det #(.W(NSTAT)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (st_lvl),
    .rise_o (st_rise)
  );

  pwm_trig1_skip #(.OFS_W(OFS_W)) u_t1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .eoc_i  (eoc_i),
    .src_i  (trig1_src_i),
    .skip_i (ctl_q.t1_skip),
    .fire_o (t1_fire)
  );

  assign t2_fire = |(cmp_vec & ctl_q.t2_en);

  always_comb begin
    unique case (ctl_q.tb_sel)
      TB_EOC:   tb_evt = eoc_i;
      TB_CMPA:  tb_evt = cmp_a_i;
      TB_TRIG1: tb_evt = t1_fire;
      default:  tb_evt = 1'b0;
    endcase
  end

  assign irq_set = tb_evt | (|(st_rise & ctl_q.st_en));

  pwm_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .ack_i (irq_ack_i),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      t1_q <= t1_fire;
      t2_q <= t2_fire;
    end
  end

  assign adc_trig1_o = t1_q;
  assign adc_trig2_o = t2_q;
endmodule

// File: rtl/pwm_evt_router_chk.sv
module pwm_evt_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eoc_i,
  input logic [2:0] cmp_vec,
  input logic [2:0] t2_en,
  input logic       irq_set,
  input logic       irq_ack_i,
  input logic       irq_o,
  input logic       adc_trig1_o,
  input logic       adc_trig2_o
);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i) |=> irq_o);

  // R9
  irq_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !irq_set) |=> !irq_o);

  // R9
  irq_set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_o);

  // R6
  trig2_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cmp_vec & t2_en)) |=> adc_trig2_o);

  // R6
  trig2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cmp_vec & t2_en)) |=> !adc_trig2_o);

  // R7
  trig1_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_trig1_o && !eoc_i) |=> !adc_trig1_o);
endmodule

bind pwm_evt_router pwm_evt_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eoc_i       (eoc_i),
  .cmp_vec     (cmp_vec),
  .t2_en       (t2_en_w),
  .irq_set     (irq_set),
  .irq_ack_i   (irq_ack_i),
  .irq_o       (irq_o),
  .adc_trig1_o (adc_trig1_o),
  .adc_trig2_o (adc_trig2_o)
);

// File: tb/pwm_evt_router_tb.sv
module pwm_evt_router_tb_top;
  localparam int PERIOD = 10;

  logic clk, rst_n, we, eoc, ca, cb, cc, src, flt, clim, ffw, syn, ack;
  logic [15:0] wdata;
  logic irq, t1, t2;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pwm_evt_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .eoc_i(eoc), .cmp_a_i(ca), .cmp_b_i(cb), .cmp_c_i(cc),
    .trig1_src_i(src), .fault_i(flt), .climit_i(clim), .ffwd_i(ffw),
    .sync_i(syn), .irq_ack_i(ack), .irq_o(irq), .adc_trig1_o(t1),
    .adc_trig2_o(t2)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // trigger 2 vectors: {enable[2:0] (C,B,A), compare[2:0] (C,B,A), expected}
  localparam logic [6:0] T2_VEC [8] = '{
    {3'b000, 3'b111, 1'b0}, {3'b001, 3'b001, 1'b1},
    {3'b001, 3'b110, 1'b0}, {3'b010, 3'b010, 1'b1},
    {3'b100, 3'b100, 1'b1}, {3'b100, 3'b011, 1'b0},
    {3'b110, 3'b001, 1'b0}, {3'b111, 3'b101, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [15:0] d);
    we = 1'b1; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic set_stat(int i, logic v);
    case (i)
      3: flt = v;
      2: clim = v;
      1: ffw = v;
      default: syn = v;
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; we = 0; wdata = '0; eoc = 0; ca = 0; cb = 0; cc = 0;
    src = 0; flt = 1'b1; clim = 0; ffw = 0; syn = 0; ack = 0;
    repeat (3) tick();
    // R10 reset state of outputs
    chk("R10 irq reset", irq, 1'b0);
    chk("R10 trig1 reset", t1, 1'b0);
    chk("R10 trig2 reset", t2, 1'b0);
    rst_n = 1'b1;
    tick();
    // R10 default selector is end of cycle, default skip is zero
    eoc = 1; src = 1; tick(); eoc = 0; src = 0;
    chk("R10 default eoc irq", irq, 1'b1);
    chk("R10 default trig1 no skip", t1, 1'b1);
    do_ack();
    chk("R9 ack clears", irq, 1'b0);

    // R3 fault high since reset, now enabled: no request
    wr(16'h8300);
    tick(); tick();
    chk("R3 held-from-reset level", irq, 1'b0);

    // R1 / R2 fault edge then hold
    flt = 0; tick();
    flt = 1; tick();
    chk("R1 fault rising edge", irq, 1'b1);
    do_ack();
    tick(); tick();
    chk("R2 held level no re-request", irq, 1'b0);
    flt = 0; tick();

    // R1 each enable gates only its own input; R5 with selector off
    for (int i = 0; i < 4; i++) begin
      wr(16'h0300 | (16'h1000 << i));
      set_stat((i + 1) % 4, 1'b1); tick(); set_stat((i + 1) % 4, 1'b0);
      tick();
      chk("R1 other input disabled", irq, 1'b0);
      set_stat(i, 1'b1); tick(); set_stat(i, 1'b0);
      chk("R1 R5 enabled input with selector off", irq, 1'b1);
      do_ack();
    end
    // R5 time-base events masked
    eoc = 1; ca = 1; tick(); eoc = 0; ca = 0;
    chk("R5 selector off masks time base", irq, 1'b0);

    // R4 selector 00
    wr(16'h0000);
    ca = 1; tick(); ca = 0;
    chk("R4 sel00 ignores compare A", irq, 1'b0);
    eoc = 1; tick(); eoc = 0;
    chk("R4 sel00 end of cycle", irq, 1'b1);
    do_ack();
    // R4 selector 01
    wr(16'h0100);
    eoc = 1; tick(); eoc = 0;
    chk("R4 sel01 ignores eoc", irq, 1'b0);
    ca = 1; tick(); ca = 0;
    chk("R4 sel01 compare A", irq, 1'b1);
    do_ack();
    // R4 selector 10
    wr(16'h0200);
    eoc = 1; tick(); eoc = 0;
    chk("R4 sel10 ignores eoc", irq, 1'b0);
    src = 1; tick(); src = 0;
    chk("R4 sel10 trigger 1 irq", irq, 1'b1);
    chk("R4 sel10 trigger 1 pulse", t1, 1'b1);
    do_ack();

    // R9 sticky, event with ack keeps it set
    wr(16'h0000);
    eoc = 1; tick(); eoc = 0;
    tick(); tick();
    chk("R9 sticky without ack", irq, 1'b1);
    eoc = 1; ack = 1; tick(); eoc = 0; ack = 0;
    chk("R9 event with ack keeps set", irq, 1'b1);
    do_ack();
    chk("R9 plain ack clears", irq, 1'b0);

    // R11 write cycle uses old setting
    wr(16'h0300);
    we = 1; wdata = 16'h0100; ca = 1; tick(); we = 0; ca = 0;
    chk("R11 event in write cycle uses old selector", irq, 1'b0);
    ca = 1; tick(); ca = 0;
    chk("R11 new selector after write", irq, 1'b1);
    do_ack();

    // R6 table walk
    for (int k = 0; k < 8; k++) begin
      wr(16'h0300 | (16'(T2_VEC[k][6:4]) << 5));
      {cc, cb, ca} = T2_VEC[k][3:1];
      tick();
      {cc, cb, ca} = 3'b000;
      chk("R6 trigger 2 source enable", t2, T2_VEC[k][0]);
      tick();
      chk("R6 trigger 2 single pulse", t2, 1'b0);
    end

    // R7 skip of 2
    wr(16'h0302);
    eoc = 1; tick(); eoc = 0;
    src = 1; tick(); chk("R7 skip2 event1", t1, 1'b0);
    tick(); chk("R7 skip2 event2", t1, 1'b0);
    tick(); chk("R7 skip2 event3 fires", t1, 1'b1);
    tick(); chk("R7 later event ignored", t1, 1'b0);
    src = 0;
    // R7 maximum skip 31
    wr(16'h031F);
    eoc = 1; tick(); eoc = 0;
    begin
      int early = 0;
      for (int j = 0; j < 31; j++) begin
        src = 1; tick();
        if (t1) early++;
      end
      chk("R7 skip31 no early pulse", early != 0, 1'b0);
    end
    tick(); src = 0;
    chk("R7 skip31 event32 fires", t1, 1'b1);

    // R8 reload on end of cycle
    wr(16'h0301);
    eoc = 1; tick(); eoc = 0;
    src = 1; tick(); chk("R8 skip1 first", t1, 1'b0);
    tick(); chk("R8 skip1 second fires", t1, 1'b1);
    src = 0;
    eoc = 1; src = 1; tick(); eoc = 0;
    chk("R8 eoc-cycle event counted, skipped", t1, 1'b0);
    tick(); src = 0;
    chk("R8 fires after reload", t1, 1'b1);

    tick();
    finish_run();
  end
endmodule